// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 32-bit virtual address into a 28-bit real byte address by fetching segment descriptors, and page descriptors where needed, from memory. It also checks the access rights of the requesting process. The top 14 bits of the virtual address are the segment number and the low 18 bits are the byte offset inside the segment. The top bit of the segment number picks one of two descriptor tables: a local table for the lower half of the segment space, a public table for the upper half. Each table is described by a base address and a highest valid index.

A request is a one-cycle `req` pulse carrying the address, the access kind and the process level. The walker then issues 64-bit descriptor reads on a valid/ready read port and takes each reply on a response strobe. Descriptors marked as shared are followed as pointers to further descriptors, to a bounded depth. A paged segment costs one more read to fetch its page descriptor. The walk ends with a one-cycle `done` pulse that carries either the real address or a fault code. A lower level number means more privilege.

Segment descriptor layout (64 bits): bit 63 present, 62 shared, 61 paged, 60 execute allowed, 59:56 read level, 55:52 write level, 50:40 last valid 128-byte block of the segment, 27:0 real address. All other bits are ignored. Page descriptor layout: bit 63 present, 27:10 page frame address.

Top module: `segx_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `mem_rd_valid` are all 0.
- R2: If segment bit 13 is 0 the local table is used, otherwise the public table. The table index is segment bits 12:0. If the index exceeds that table's limit, `done` rises on the clock edge that samples `req`, with fault 1 and no memory read. Otherwise the descriptor is read at base + index*8.
- R3: Every descriptor is one 64-bit read at an 8-byte-aligned address. `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen.
- R4: A final segment descriptor whose present bit is 0 gives fault 2.
- R5: A descriptor with the shared bit set is followed: its address field with bits 2:0 cleared is the address of the next descriptor. At most MAX_HOPS (4) such indirections are taken. A shared descriptor met after 4 indirections gives fault 2.
- R6: If offset bits 17:7 exceed the descriptor's block limit, the result is fault 4. The last byte of the last block is still allowed.
- R7: Access kind 0 is read, 1 is write, 2 is execute, 3 is reserved. Read requires level <= read level. Write requires level <= write level. Execute requires level <= read level and the execute bit. Kind 3 is always refused. A refused access gives fault 5.
- R8: For a non-paged segment, the real address is (descriptor address with bits 6:0 cleared) + offset.
- R9: For a paged segment, the page descriptor is read at (descriptor address with bits 2:0 cleared) + offset[17:10]*8. If that page descriptor's present bit is 0 the result is fault 3. Otherwise the real address is {frame bits 27:10, offset[9:0]}.
- R10: On a final segment descriptor the checks are ranked: not present (2) first, then block limit (4), then rights (5). All three are settled before any page read is made.
- R11: `done` is a one-cycle pulse. When the fault code is nonzero, `real_addr` is 0. Fault code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start pulse, sampled while idle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_level | input | 4 | Process level (lower is more privileged) |
| loc_base | input | 28 | Local table base address |
| loc_limit | input | 13 | Local table highest index |
| pub_base | input | 28 | Public table base address |
| pub_limit | input | 13 | Public table highest index |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid for one cycle |
| fault | output | 3 | 0 ok, 1 table, 2 segment absent, 3 page absent, 4 block limit, 5 rights |
| real_addr | output | 28 | Translated real byte address |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rd_addr | output | 28 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Descriptor read data |

## Verification
The block-limit check and the rights check look at the same descriptor in the same cycle. So do the present check and both of the others. The bench builds descriptors that break the limit and the rights together, and descriptors that are absent while also breaking both. It then expects the higher-ranked code alone (4, then 2), so a reversed ranking shows up as the wrong code. A second overlap is a request that stalls on the read port while an indirection hop is being counted. That walk is repeated with `mem_rd_ready` throttled, and it must give the same address and the same read count as the unthrottled walk.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int VA_W  = 32;
    localparam int SEG_W = 14;
    localparam int OFF_W = 18;
    localparam int IDX_W = SEG_W - 1;
    localparam int RA_W  = 28;
    localparam int LV_W  = 4;
    localparam int LIM_W = 11;
    localparam int PG_SH = 10;
    localparam int BLK_SH = 7;
    localparam int DW_SH = 3;

    typedef enum logic [2:0] {
        F_NONE  = 3'd0,
        F_TBL   = 3'd1,
        F_SEGNA = 3'd2,
        F_PGNA  = 3'd3,
        F_LIMIT = 3'd4,
        F_PROT  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        K_RD  = 2'd0,
        K_WR  = 2'd1,
        K_EX  = 2'd2,
        K_RSV = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SREQ, S_SWAIT, S_PREQ, S_PWAIT
    } st_e;

    typedef struct packed {
        logic             present;
        logic             shared;
        logic             paged;
        logic             xok;
        logic [LV_W-1:0]  rd_lvl;
        logic [LV_W-1:0]  wr_lvl;
        logic             pad_a;
        logic [LIM_W-1:0] blk_lim;
        logic [11:0]      pad_b;
        logic [RA_W-1:0]  addr;
    } sdesc_t;

    typedef struct packed {
        logic                present;
        logic [34:0]         pad;
        logic [RA_W-PG_SH-1:0] frame;
        logic [PG_SH-1:0]    low;
    } pdesc_t;
endpackage

// File: rtl/segx_root_sel.sv
module segx_root_sel
    import segx_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [RA_W-1:0]  loc_base,
    input  logic [IDX_W-1:0] loc_limit,
    input  logic [RA_W-1:0]  pub_base,
    input  logic [IDX_W-1:0] pub_limit,
    output logic [RA_W-1:0]  ent_addr,
    output logic             over
);
    logic [IDX_W-1:0] idx;
    logic             is_pub;

    always_comb begin
        is_pub   = seg[SEG_W-1];
        idx      = seg[IDX_W-1:0];
        over     = is_pub ? (idx > pub_limit) : (idx > loc_limit);
        ent_addr = (is_pub ? pub_base : loc_base)
                 + {{(RA_W-IDX_W-DW_SH){1'b0}}, idx, {DW_SH{1'b0}}};
    end
endmodule

// File: rtl/segx_rights.sv
module segx_rights
    import segx_pkg::*;
(
    input  sdesc_t           ent,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       kind,
    input  logic [LV_W-1:0]  lvl,
    output fault_e           code
);
    logic beyond;
    logic allowed;

    always_comb begin
        beyond = off[OFF_W-1:BLK_SH] > ent.blk_lim;
        unique case (kind_e'(kind))
            K_RD:    allowed = (lvl <= ent.rd_lvl);
            K_WR:    allowed = (lvl <= ent.wr_lvl);
            K_EX:    allowed = (lvl <= ent.rd_lvl) && ent.xok;
            default: allowed = 1'b0;
        endcase
        if (!ent.present)  code = F_SEGNA;
        else if (beyond)   code = F_LIMIT;
        else if (!allowed) code = F_PROT;
        else               code = F_NONE;
    end
endmodule

// File: rtl/segx_walker.sv
module segx_walker
    import segx_pkg::*;
#(
    parameter int MAX_HOPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [LV_W-1:0]   req_level,
    input  logic [RA_W-1:0]   loc_base,
    input  logic [IDX_W-1:0]  loc_limit,
    input  logic [RA_W-1:0]   pub_base,
    input  logic [IDX_W-1:0]  pub_limit,
    output logic              busy,
    output logic              done,
    output logic [2:0]        fault,
    output logic [RA_W-1:0]   real_addr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [RA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    typedef struct packed {
        st_e              st;
        logic [HOP_W-1:0] hops;
        logic [VA_W-1:0]  va;
        logic [1:0]       kind;
        logic [LV_W-1:0]  lvl;
        logic [RA_W-1:0]  addr;
        logic             done;
        fault_e           fault;
        logic [RA_W-1:0]  raddr;
    } regs_t;

    regs_t q, d;

    logic [RA_W-1:0] root_addr;
    logic            root_over;
    sdesc_t          sd;
    pdesc_t          pd;
    fault_e          chk;
    logic [OFF_W-1:0] off_q;

    assign sd    = sdesc_t'(mem_rsp_data);
    assign pd    = pdesc_t'(mem_rsp_data);
    assign off_q = q.va[OFF_W-1:0];

    segx_root_sel u_root (
        .seg       (req_vaddr[VA_W-1:OFF_W]),
        .loc_base  (loc_base),
        .loc_limit (loc_limit),
        .pub_base  (pub_base),
        .pub_limit (pub_limit),
        .ent_addr  (root_addr),
        .over      (root_over)
    );

    segx_rights u_rights (
        .ent  (sd),
        .off  (off_q),
        .kind (q.kind),
        .lvl  (q.lvl),
        .code (chk)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            S_IDLE: if (req) begin
                d.va   = req_vaddr;
                d.kind = req_kind;
                d.lvl  = req_level;
                d.hops = '0;
                if (root_over) begin
                    d.done  = 1'b1;
                    d.fault = F_TBL;
                    d.raddr = '0;
                end else begin
                    d.addr = root_addr;
                    d.st   = S_SREQ;
                end
            end
            S_SREQ: if (mem_rd_ready) d.st = S_SWAIT;
            S_SWAIT: if (mem_rsp_valid) begin
                if (sd.shared) begin
                    if (q.hops == HOP_W'(MAX_HOPS)) begin
                        d.st    = S_IDLE;
                        d.done  = 1'b1;
                        d.fault = F_SEGNA;
                        d.raddr = '0;
                    end else begin
                        d.hops = q.hops + 1'b1;
                        d.addr = {sd.addr[RA_W-1:DW_SH], {DW_SH{1'b0}}};
                        d.st   = S_SREQ;
                    end
                end else if (chk != F_NONE) begin
                    d.st    = S_IDLE;
                    d.done  = 1'b1;
                    d.fault = chk;
                    d.raddr = '0;
                end else if (sd.paged) begin
                    d.addr = {sd.addr[RA_W-1:DW_SH], {DW_SH{1'b0}}}
                           + {{(RA_W-(OFF_W-PG_SH)-DW_SH){1'b0}},
                              off_q[OFF_W-1:PG_SH], {DW_SH{1'b0}}};
                    d.st   = S_PREQ;
                end else begin
                    d.st    = S_IDLE;
                    d.done  = 1'b1;
                    d.fault = F_NONE;
                    d.raddr = {sd.addr[RA_W-1:BLK_SH], {BLK_SH{1'b0}}}
                            + {{(RA_W-OFF_W){1'b0}}, off_q};
                end
            end
            S_PREQ: if (mem_rd_ready) d.st = S_PWAIT;
            S_PWAIT: if (mem_rsp_valid) begin
                d.st   = S_IDLE;
                d.done = 1'b1;
                if (!pd.present) begin
                    d.fault = F_PGNA;
                    d.raddr = '0;
                end else begin
                    d.fault = F_NONE;
                    d.raddr = {pd.frame, off_q[PG_SH-1:0]};
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.hops  <= '0;
            q.va    <= '0;
            q.kind  <= '0;
            q.lvl   <= '0;
            q.addr  <= '0;
            q.done  <= 1'b0;
            q.fault <= F_NONE;
            q.raddr <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st != S_IDLE);
    assign done         = q.done;
    assign fault        = q.fault;
    assign real_addr    = q.raddr;
    assign mem_rd_valid = (q.st == S_SREQ) || (q.st == S_PREQ);
    assign mem_rd_addr  = q.addr;

    // R1: no read request while idle
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_valid);

    // R2: an out-of-range index ends the request at the next edge with fault 1
    a_r2_table_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req && root_over) |=> (done && fault == 3'd1 && !mem_rd_valid));

    // R3: a stalled request keeps its address
    a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R3: descriptor reads are double-word aligned
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[DW_SH-1:0] == '0));

    // R5: the indirection count never passes its bound
    a_r5_hop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.hops <= HOP_W'(MAX_HOPS));

    // R11: a fault result carries a zero address and a known code
    a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 3'd0) |-> (real_addr == '0 && fault <= 3'd5));
endmodule

// File: tb/sim_segx_walker.sv
module sim_segx_walker;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [3:0]  req_level = '0;
    logic [27:0] loc_base = 28'h0100000;
    logic [12:0] loc_limit = 13'd100;
    logic [27:0] pub_base = 28'h0200000;
    logic [12:0] pub_limit = 13'd20;
    logic        busy, done;
    logic [2:0]  fault;
    logic [27:0] real_addr;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [27:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int total = 0;
    int bad = 0;
    int reads = 0;
    int cyc = 0;
    bit stall = 1'b0;
    logic [63:0] mem [logic [27:0]];

    always #(CLK_P/2) clk = ~clk;

    segx_walker u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_level(req_level),
        .loc_base(loc_base), .loc_limit(loc_limit),
        .pub_base(pub_base), .pub_limit(pub_limit),
        .busy(busy), .done(done), .fault(fault), .real_addr(real_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_seg(input bit av, input bit sh, input bit pg, input bit ex,
                                           input logic [3:0] rl, input logic [3:0] wl,
                                           input logic [10:0] lim, input logic [27:0] a);
        return {av, sh, pg, ex, rl, wl, 1'b0, lim, 12'b0, a};
    endfunction

    function automatic logic [63:0] mk_pg(input bit av, input logic [27:0] frame);
        return {av, 35'b0, frame[27:10], 10'b0};
    endfunction

    function automatic logic [63:0] rdmem(input logic [27:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    // memory model: one-cycle response after each accepted read
    initial begin
        bit pend = 1'b0;
        bit prev_stall = 1'b0;
        logic [27:0] paddr = '0;
        logic [27:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (prev_stall)
                check(mem_rd_valid && mem_rd_addr == prev_addr, "R3 stalled request held",
                      {4'h0, mem_rd_addr}, {4'h0, prev_addr});
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rdmem(paddr);
                pend = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            mem_rd_ready = stall ? (cyc % 3 == 2) : 1'b1;
            prev_stall = mem_rd_valid && !mem_rd_ready;
            prev_addr  = mem_rd_addr;
            if (mem_rd_valid && mem_rd_ready) begin
                pend  = 1'b1;
                paddr = mem_rd_addr;
                reads++;
            end
        end
    end

    task automatic run(input logic [13:0] seg, input logic [17:0] off, input logic [1:0] k,
                       input logic [3:0] lv, input string tag,
                       input logic [2:0] exp_f, input logic [27:0] exp_a, input int exp_reads);
        int guard = 0;
        @(negedge clk);
        reads = 0;
        req = 1'b1; req_vaddr = {seg, off}; req_kind = k; req_level = lv;
        @(negedge clk);
        req = 1'b0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(fault == exp_f, {tag, " fault code"}, {29'h0, fault}, {29'h0, exp_f});
        check(real_addr == exp_a, {tag, " real address"}, {4'h0, real_addr}, {4'h0, exp_a});
        if (exp_reads >= 0)
            check(reads == exp_reads, {tag, " read count"}, reads, exp_reads);
        @(negedge clk);
        check(!done, "R11 done is a single pulse", {31'h0, done}, 32'h0);
    endtask

    task automatic t_reset;
        check(!busy && !done && !mem_rd_valid, "R1 idle after reset",
              {29'h0, busy, done, mem_rd_valid}, 32'h0);
    endtask

    task automatic t_basic;
        run(14'd5, 18'h00123, 2'd0, 4'd3, "R8 local read", 3'd0, 28'h0234623, 1);
        run(14'h2007, 18'h3FFFF, 2'd0, 4'd15, "R2 public table", 3'd0, 28'h0AFCD7F, 1);
    endtask

    task automatic t_table;
        run(14'h2015, 18'h0, 2'd0, 4'd0, "R2 public index above limit", 3'd1, 28'h0, 0);
        run(14'd100, 18'h0, 2'd0, 4'd0, "R2 index equal to limit reads entry", 3'd2, 28'h0, 1);
    endtask

    task automatic t_absent;
        run(14'd8, 18'h0, 2'd0, 4'd0, "R4 segment absent", 3'd2, 28'h0, 1);
    endtask

    task automatic t_limit;
        run(14'd5, 18'h00A7F, 2'd0, 4'd0, "R6 last allowed byte", 3'd0, 28'h0234F7F, 1);
        run(14'd5, 18'h00A80, 2'd0, 4'd0, "R6 first byte past limit", 3'd4, 28'h0, 1);
    endtask

    task automatic t_rights;
        run(14'd5, 18'h0, 2'd0, 4'd4, "R7 read level too high", 3'd5, 28'h0, 1);
        run(14'd5, 18'h10, 2'd1, 4'd2, "R7 write at write level", 3'd0, 28'h0234510, 1);
        run(14'd5, 18'h0, 2'd1, 4'd3, "R7 write above write level", 3'd5, 28'h0, 1);
        run(14'd5, 18'h0, 2'd2, 4'd0, "R7 execute without execute bit", 3'd5, 28'h0, 1);
        run(14'd6, 18'h7F, 2'd2, 4'd3, "R7 execute allowed", 3'd0, 28'h040007F, 1);
        run(14'd6, 18'h0, 2'd2, 4'd4, "R7 execute level too high", 3'd5, 28'h0, 1);
        run(14'd6, 18'h0, 2'd3, 4'd0, "R7 reserved kind refused", 3'd5, 28'h0, 1);
    endtask

    task automatic t_rank;
        run(14'd9, 18'h01000, 2'd0, 4'd5, "R10 limit ranks above rights", 3'd4, 28'h0, 1);
        run(14'd10, 18'h01000, 2'd0, 4'd5, "R10 absent ranks above all", 3'd2, 28'h0, 1);
        run(14'd15, 18'h01000, 2'd0, 4'd0, "R10 limit fault before page read", 3'd4, 28'h0, 1);
    endtask

    task automatic t_shared;
        run(14'd11, 18'h10, 2'd0, 4'd7, "R5 two-level chain", 3'd0, 28'h0600010, 3);
        run(14'd13, 18'h20, 2'd0, 4'd0, "R5 four indirections allowed", 3'd0, 28'h0700020, 5);
        run(14'd12, 18'h0, 2'd0, 4'd0, "R5 fifth shared entry faults", 3'd2, 28'h0, 5);
    endtask

    task automatic t_paged;
        run(14'd14, 18'h00C57, 2'd0, 4'd0, "R9 paged translation", 3'd0, 28'h00ABC57, 2);
        run(14'd14, 18'h00457, 2'd0, 4'd0, "R9 page absent", 3'd3, 28'h0, 2);
    endtask

    task automatic t_stall;
        stall = 1'b1;
        run(14'd11, 18'h10, 2'd0, 4'd7, "R3 throttled chain", 3'd0, 28'h0600010, 3);
        run(14'd14, 18'h00C57, 2'd0, 4'd0, "R3 throttled paged", 3'd0, 28'h00ABC57, 2);
        stall = 1'b0;
    endtask

    initial begin
        mem[28'h0100028] = mk_seg(1, 0, 0, 0, 4'd3, 4'd2, 11'd20, 28'h0234500);
        mem[28'h0100030] = mk_seg(1, 0, 0, 1, 4'd3, 4'd3, 11'd0, 28'h0400000);
        mem[28'h0100040] = mk_seg(0, 0, 0, 1, 4'd15, 4'd15, 11'h7FF, 28'h0410000);
        mem[28'h0100048] = mk_seg(1, 0, 0, 0, 4'd0, 4'd0, 11'd0, 28'h0420000);
        mem[28'h0100050] = mk_seg(0, 0, 0, 0, 4'd0, 4'd0, 11'd0, 28'h0430000);
        mem[28'h0100078] = mk_seg(1, 0, 1, 0, 4'd15, 4'd15, 11'd0, 28'h0310000);
        mem[28'h0200038] = mk_seg(1, 0, 0, 0, 4'd15, 4'd15, 11'h7FF, 28'h0ABCD80);
        // shared chain of two
        mem[28'h0100058] = mk_seg(0, 1, 0, 0, 4'd0, 4'd0, 11'd0, 28'h050000F);
        mem[28'h0500008] = mk_seg(0, 1, 0, 0, 4'd0, 4'd0, 11'd0, 28'h0500010);
        mem[28'h0500010] = mk_seg(1, 0, 0, 0, 4'd7, 4'd7, 11'd5, 28'h0600000);
        // five shared entries
        mem[28'h0100060] = mk_seg(1, 1, 0, 0, 4'd15, 4'd15, 11'h7FF, 28'h0510000);
        for (int i = 0; i < 4; i++)
            mem[28'h0510000 + 28'(i*8)] = mk_seg(1, 1, 0, 0, 4'd15, 4'd15, 11'h7FF, 28'h0510008 + 28'(i*8));
        // four indirections then a final entry
        mem[28'h0100068] = mk_seg(1, 1, 0, 0, 4'd15, 4'd15, 11'h7FF, 28'h0520000);
        for (int i = 0; i < 3; i++)
            mem[28'h0520000 + 28'(i*8)] = mk_seg(1, 1, 0, 0, 4'd15, 4'd15, 11'h7FF, 28'h0520008 + 28'(i*8));
        mem[28'h0520018] = mk_seg(1, 0, 0, 0, 4'd15, 4'd15, 11'h7FF, 28'h0700000);
        // paged segment
        mem[28'h0100070] = mk_seg(1, 0, 1, 0, 4'd15, 4'd15, 11'h7FF, 28'h0300000);
        mem[28'h0300018] = mk_pg(1, 28'h00ABC00);
        mem[28'h0300008] = mk_pg(0, 28'h00DD000);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_table();
        t_absent();
        t_limit();
        t_rights();
        t_rank();
        t_shared();
        t_paged();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule